// File: doc/BRIEF.md
# Dual-Channel DAC Control Core

This block is the digital half of a two-channel voltage-output converter. A write-only, three-wire serial slave takes 24-bit command frames from a host. Each frame is decoded into one of five actions: write a channel's input code, transfer input codes into the output latches, write and transfer together, set a channel's output termination, or set the reference source. The latched codes, per-channel termination modes and reference controls leave the block and drive the analog section.

Each channel is double-buffered. A staged code has no effect on the output until a transfer command moves it into the latch, and one transfer can move both channels in the same cycle. An active-low clear input zeroes both stages of both channels asynchronously, which forces zero-scale output. Termination and reference settings survive a clear. After power-on reset every code is zero, both channels run normally and the internal reference is off, so an external reference can be used.

The serial pins are oversampled by the system clock through synchronizers. The system clock must run at least four times faster than the serial clock.

Top module: `dac2_ctrl_core`

## Requirements
- R1: After reset, both latched codes are zero, both termination modes are 00 (normal), ref_sel is 00 and ref_en is 0.
- R2: A frame reaches the block as 24 bits, MSB first, shifted in on serial-clock falling edges while csb_n is low. Bits 23:20 hold the opcode, bits 19:16 the channel select and bits 15:0 the data word. Opcode 0x0 writes the input code and leaves the latched code unchanged.
- R3: Opcode 0x1 copies the selected channels' input codes into their latches. With select 0xF, both channels update in the same cycle.
- R4: Opcode 0x2 writes the input code and the latch of each selected channel with the frame's code.
- R5: Select 0x0 addresses channel A, 0x1 channel B and 0xF both. Any other select value changes nothing.
- R6: The code is left-justified: it is data bits 15 down to 16-RES, and the lower data bits are ignored.
- R7: While clr_n is low, both stages of both channels are zero, and code writes and transfers are ignored. Termination and reference settings are neither cleared nor blocked.
- R8: Opcode 0x4 sets the selected channels' termination mode from data bits 1:0: 00 normal, 01 1 kΩ, 10 100 kΩ, 11 high impedance.
- R9: Opcode 0x7 sets ref_sel from data bits 1:0, whatever the channel select: 00 external, 01 2.048 V, 10 2.500 V, 11 4.096 V. ref_en is 1 exactly when ref_sel is not 00.
- R10: A frame that ends with csb_n rising before 24 falling edges changes nothing.
- R11: Falling edges after the 24th within one csb_n low period are ignored.
- R12: Opcodes other than 0x0, 0x1, 0x2, 0x4 and 0x7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must run at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| clr_n | input | 1 | Asynchronous active-low clear of both code stages |
| csb_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock; data is taken on its falling edge |
| sdi | input | 1 | Serial data in, MSB first |
| dac_a | output | RES | Latched code, channel A |
| dac_b | output | RES | Latched code, channel B |
| pd_a | output | 2 | Termination mode, channel A |
| pd_b | output | 2 | Termination mode, channel B |
| ref_sel | output | 2 | Reference source select |
| ref_en | output | 1 | Internal reference enable |

## Verification
The bench checks the double buffering by staging a code and confirming that the latch holds its old value until a transfer arrives. A design that wired the code register straight to the output would fail here. Frames cut short at 23 bits and frames stretched to 26 clocks are sent next. A design that acted on a partial frame, or kept shifting past bit 24, would corrupt a channel. Frames are also sent while clear is held low. A design that let those writes land, or that cleared termination and reference along with the codes, would show wrong values once clear is released. Random frames with illegal opcodes and selects are mixed in, and these would expose a decoder that matched on partial fields.

// File: rtl/dac2_pkg.sv
package dac2_pkg;
   localparam int FRAME_W = 24;
   localparam int WORD_W  = 16;

   typedef enum logic [3:0] {
      OP_WR   = 4'h0,
      OP_LD   = 4'h1,
      OP_WRLD = 4'h2,
      OP_PD   = 4'h4,
      OP_REF  = 4'h7
   } op_e;

   typedef enum logic [1:0] {
      PD_ON   = 2'b00,
      PD_1K   = 2'b01,
      PD_100K = 2'b10,
      PD_HIZ  = 2'b11
   } pd_e;

   typedef enum logic [1:0] {
      REF_EXT   = 2'b00,
      REF_2V048 = 2'b01,
      REF_2V500 = 2'b10,
      REF_4V096 = 2'b11
   } ref_e;

   localparam logic [3:0] SEL_ALL = 4'hF;
endpackage

// File: rtl/dac2_sync.sv
module dac2_sync #(
   parameter int          STAGES  = 2,
   parameter int          W       = 1,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 1) begin : g_bad_stages
      $error("dac2_sync: STAGES must be at least 1");
   end

   logic [W-1:0] pipe [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) pipe[0] <= RST_VAL;
            else        pipe[0] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) pipe[s] <= RST_VAL;
            else        pipe[s] <= pipe[s-1];
      end
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/dac2_spi_rx.sv
module dac2_spi_rx #(
   parameter int SYNC_STAGES = 2,
   parameter int FRAME_W     = 24
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               csb_n,
   input  logic               sclk,
   input  logic               sdi,
   output logic               frm_vld,
   output logic [FRAME_W-1:0] frm_data
);
   localparam int CW = $clog2(FRAME_W + 1);

   if (FRAME_W < 2) begin : g_bad_frame
      $error("dac2_spi_rx: FRAME_W must be at least 2");
   end

   logic [2:0]   pins_s;
   logic         csb_s, sclk_s, sdi_s, sclk_q, fall;
   logic [CW-1:0] cnt;

   dac2_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b100)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({csb_n, sclk, sdi}),
      .q     (pins_s)
   );

   assign {csb_s, sclk_s, sdi_s} = pins_s;
   assign fall = sclk_q & ~sclk_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q   <= 1'b0;
         cnt      <= '0;
         frm_data <= '0;
         frm_vld  <= 1'b0;
      end else begin
         sclk_q  <= sclk_s;
         frm_vld <= 1'b0;
         if (csb_s) begin
            cnt <= '0;
         end else if (fall && (cnt < CW'(FRAME_W))) begin
            frm_data <= {frm_data[FRAME_W-2:0], sdi_s};
            cnt      <= cnt + 1'b1;
            if (cnt == CW'(FRAME_W - 1)) frm_vld <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/dac2_chan.sv
module dac2_chan
   import dac2_pkg::*;
#(
   parameter int RES = 12
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr_n,
   input  logic           wr_code,
   input  logic           ld,
   input  logic           wr_pd,
   input  logic [RES-1:0] code_in,
   input  logic [1:0]     pd_in,
   output logic [RES-1:0] dac,
   output logic [1:0]     pd
);
   logic [RES-1:0] code_q;

   always_ff @(posedge clk or negedge rst_n or negedge clr_n) begin
      if (!rst_n || !clr_n) begin
         code_q <= '0;
         dac    <= '0;
      end else begin
         if (wr_code) code_q <= code_in;
         if (ld)      dac    <= wr_code ? code_in : code_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pd <= PD_ON;
      else if (wr_pd) pd <= pd_in;
   end
endmodule

// File: rtl/dac2_ctrl_core.sv
module dac2_ctrl_core
   import dac2_pkg::*;
#(
   parameter int RES         = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr_n,
   input  logic           csb_n,
   input  logic           sclk,
   input  logic           sdi,
   output logic [RES-1:0] dac_a,
   output logic [RES-1:0] dac_b,
   output logic [1:0]     pd_a,
   output logic [1:0]     pd_b,
   output logic [1:0]     ref_sel,
   output logic           ref_en
);
   localparam int NCH = 2;

   if (RES != 8 && RES != 10 && RES != 12) begin : g_bad_res
      $error("dac2_ctrl_core: RES must be 8, 10 or 12");
   end

   logic               frm_vld;
   logic [FRAME_W-1:0] frm_data;
   logic [3:0]         op, sel;
   logic [WORD_W-1:0]  word;
   logic [RES-1:0]     code_in;
   logic [RES-1:0]     dac_arr [NCH];
   logic [1:0]         pd_arr  [NCH];
   logic [1:0]         ref_q;

   dac2_spi_rx #(.SYNC_STAGES(SYNC_STAGES), .FRAME_W(FRAME_W)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .csb_n    (csb_n),
      .sclk     (sclk),
      .sdi      (sdi),
      .frm_vld  (frm_vld),
      .frm_data (frm_data)
   );

   assign op      = frm_data[FRAME_W-1 -: 4];
   assign sel     = frm_data[FRAME_W-5 -: 4];
   assign word    = frm_data[WORD_W-1:0];
   assign code_in = word[WORD_W-1 -: RES];

   for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      logic hit, wr, ld, wpd;
      assign hit = (sel == 4'(ch)) || (sel == SEL_ALL);
      assign wr  = frm_vld && hit && (op == OP_WR || op == OP_WRLD);
      assign ld  = frm_vld && hit && (op == OP_LD || op == OP_WRLD);
      assign wpd = frm_vld && hit && (op == OP_PD);

      dac2_chan #(.RES(RES)) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr_n   (clr_n),
         .wr_code (wr),
         .ld      (ld),
         .wr_pd   (wpd),
         .code_in (code_in),
         .pd_in   (word[1:0]),
         .dac     (dac_arr[ch]),
         .pd      (pd_arr[ch])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       ref_q <= REF_EXT;
      else if (frm_vld && op == OP_REF) ref_q <= word[1:0];
   end

   assign dac_a   = dac_arr[0];
   assign dac_b   = dac_arr[1];
   assign pd_a    = pd_arr[0];
   assign pd_b    = pd_arr[1];
   assign ref_sel = ref_q;
   assign ref_en  = (ref_q != REF_EXT);
endmodule

// File: rtl/dac2_ctrl_core_chk.sv
module dac2_ctrl_core_chk #(
   parameter int RES = 12
) (
   input logic           clk,
   input logic           rst_n,
   input logic           clr_n,
   input logic           frm_vld,
   input logic [23:0]    frm_data,
   input logic [RES-1:0] dac_a,
   input logic [RES-1:0] dac_b,
   input logic [1:0]     pd_a,
   input logic [1:0]     pd_b,
   input logic [1:0]     ref_sel,
   input logic           ref_en
);
   logic [3:0] op, sel;
   logic       sel_ok;
   assign op     = frm_data[23:20];
   assign sel    = frm_data[19:16];
   assign sel_ok = (sel == 4'h0) || (sel == 4'h1) || (sel == 4'hF);

   a_r2_write_keeps_latch: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_vld && op == 4'h0 && clr_n) |=> (!clr_n || ($stable(dac_a) && $stable(dac_b))));

   a_r4_wrld_sets_a: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_vld && op == 4'h2 && sel == 4'h0 && clr_n) |=>
         (!clr_n || dac_a == $past(frm_data[15:16-RES])));

   a_r5_bad_sel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_vld && !sel_ok && op != 4'h7 && clr_n) |=>
         (!clr_n || ($stable(dac_a) && $stable(dac_b) && $stable(pd_a) && $stable(pd_b))));

   a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_n |-> (dac_a == '0 && dac_b == '0));

   a_r8_settings_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !frm_vld |=> ($stable(pd_a) && $stable(pd_b) && $stable(ref_sel)));

   a_r9_ref_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_vld && op == 4'h7) |=> (ref_en == ($past(frm_data[1:0]) != 2'b00)));
endmodule

bind dac2_ctrl_core dac2_ctrl_core_chk #(.RES(RES)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .clr_n    (clr_n),
   .frm_vld  (frm_vld),
   .frm_data (frm_data),
   .dac_a    (dac_a),
   .dac_b    (dac_b),
   .pd_a     (pd_a),
   .pd_b     (pd_b),
   .ref_sel  (ref_sel),
   .ref_en   (ref_en)
);

// File: tb/dac2_ctrl_core_bench.sv
module dac2_ctrl_core_bench;
   localparam int RES = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b1;
   logic clr_n = 1'b1;
   logic csb_n = 1'b1;
   logic sclk = 1'b0;
   logic sdi = 1'b0;
   logic [RES-1:0] dac_a, dac_b;
   logic [1:0] pd_a, pd_b, ref_sel;
   logic ref_en;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [RES-1:0] m_code [2];
   logic [RES-1:0] m_dac  [2];
   logic [1:0]     m_pd   [2];
   logic [1:0]     m_ref;

   always #4 clk = ~clk;

   dac2_ctrl_core #(.RES(RES)) u_dac2_ctrl_core (
      .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .csb_n(csb_n), .sclk(sclk), .sdi(sdi),
      .dac_a(dac_a), .dac_b(dac_b), .pd_a(pd_a), .pd_b(pd_b),
      .ref_sel(ref_sel), .ref_en(ref_en)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      chk({req, " dac_a"}, int'(dac_a), int'(m_dac[0]));
      chk({req, " dac_b"}, int'(dac_b), int'(m_dac[1]));
      chk({req, " pd_a"}, int'(pd_a), int'(m_pd[0]));
      chk({req, " pd_b"}, int'(pd_b), int'(m_pd[1]));
      chk({req, " ref_sel"}, int'(ref_sel), int'(m_ref));
      chk({req, " ref_en"}, int'(ref_en), int'(m_ref != 2'b00));
   endtask

   function automatic void model(input logic [23:0] f);
      logic [3:0] op = f[23:20];
      logic [3:0] sel = f[19:16];
      logic [RES-1:0] c = f[15:16-RES];
      for (int ch = 0; ch < 2; ch++) begin
         bit hit = (sel == 4'(ch)) || (sel == 4'hF);
         if (!hit) continue;
         if (clr_n) begin
            if (op == 4'h0 || op == 4'h2) m_code[ch] = c;
            if (op == 4'h1 || op == 4'h2) m_dac[ch] = m_code[ch];
         end
         if (op == 4'h4) m_pd[ch] = f[1:0];
      end
      if (op == 4'h7) m_ref = f[1:0];
   endfunction

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send(input logic [23:0] f, input int nclk);
      csb_n = 1'b0;
      wait_clk(2);
      for (int i = 0; i < nclk; i++) begin
         sdi  = (i < 24) ? f[23-i] : 1'($urandom);
         sclk = 1'b1;
         wait_clk(2);
         sclk = 1'b0;
         wait_clk(2);
      end
      wait_clk(2);
      csb_n = 1'b1;
      wait_clk(8);
      if (nclk >= 24) model(f);
   endtask

   function automatic logic [23:0] mk(input logic [3:0] op, input logic [3:0] sel,
                                      input logic [15:0] d);
      return {op, sel, d};
   endfunction

   initial begin
      void'($urandom(32'h5EED_0D0C));
      for (int ch = 0; ch < 2; ch++) begin
         m_code[ch] = '0; m_dac[ch] = '0; m_pd[ch] = 2'b00;
      end
      m_ref = 2'b00;
      #1 rst_n = 1'b0;
      wait_clk(4);
      rst_n = 1'b1;
      wait_clk(4);
      check_all("R1 reset");

      send(mk(4'h0, 4'h0, 16'hABC0), 24);
      check_all("R2 write holds latch");
      chk("R2 latch unchanged", int'(dac_a), 0);
      send(mk(4'h0, 4'h1, 16'h1230), 24);
      send(mk(4'h1, 4'hF, 16'h0000), 24);
      check_all("R3 load both");
      chk("R3 dac_b loaded", int'(dac_b), 12'h123);

      send(mk(4'h2, 4'h1, 16'h7E5F), 24);
      check_all("R4 write+load B");
      chk("R6 low bits ignored", int'(dac_b), 12'h7E5);

      send(mk(4'h2, 4'h5, 16'hFFFF), 24);
      check_all("R5 bad select");

      send(mk(4'h4, 4'h0, 16'h0001), 24);
      send(mk(4'h4, 4'h1, 16'h0003), 24);
      check_all("R8 termination");
      chk("R8 pd_b hiz", int'(pd_b), 3);

      send(mk(4'h7, 4'h3, 16'h0002), 24);
      check_all("R9 reference");
      chk("R9 ref_en on", int'(ref_en), 1);

      send(mk(4'h2, 4'hF, 16'h5550), 23);
      check_all("R10 short frame");

      send(mk(4'h2, 4'h0, 16'h9990), 26);
      check_all("R11 long frame");

      send(mk(4'h3, 4'hF, 16'hFFFF), 24);
      check_all("R12 bad opcode");

      wait_clk(1);
      #2 clr_n = 1'b0;
      #1 chk("R7 async clear", int'(dac_a | dac_b), 0);
      for (int ch = 0; ch < 2; ch++) begin m_code[ch] = '0; m_dac[ch] = '0; end
      wait_clk(2);
      send(mk(4'h2, 4'hF, 16'hFFF0), 24);
      send(mk(4'h4, 4'h0, 16'h0002), 24);
      send(mk(4'h7, 4'h0, 16'h0001), 24);
      check_all("R7 during clear");
      clr_n = 1'b1;
      wait_clk(2);
      send(mk(4'h1, 4'hF, 16'h0000), 24);
      check_all("R7 after clear");

      for (int k = 0; k < 120; k++) begin
         logic [3:0] ops [7] = '{4'h0, 4'h1, 4'h2, 4'h4, 4'h7, 4'h3, 4'h9};
         logic [3:0] sels [4] = '{4'h0, 4'h1, 4'hF, 4'h6};
         send(mk(ops[$urandom_range(6)], sels[$urandom_range(3)], 16'($urandom)), 24);
         check_all("R12 random");
      end

      done = 1'b1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 150000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
      end
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule